// File: doc/BRIEF.md
# Multi-Mode Comma Character Framer

This block sits behind a deserializer. It receives the recovered serial stream ten bits per clock and decides where each 10-bit line character starts. It looks for framing characters at every possible bit offset and keeps a boundary offset. Every clock it presents one 10-bit character cut from the stream at that offset, together with the offset itself.

The framer has three ways of deciding when to move the boundary. The fast policy moves the boundary on every framing character it sees. The paired policy waits until two framing characters land on the same offset within a 50-bit span. The run policy waits until four framing characters land on the same offset in back-to-back character slots. The framing character is either the 7-bit comma or the complete K28.5, and both running-disparity forms are accepted. A reframe-enable input gates every boundary change. In every policy the output keeps delivering exactly one character per clock, so the character rate never changes when the boundary moves.

Top module: `comma_framer`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs become `boundaryOff`=0, `realignPulse`=0 and `alignedChar`=0.
- R2: `rxWord[0]` is the earliest-arriving bit. A 20-bit window is formed each cycle with the previous word in bits 0..9 and the current word in bits 10..19. The candidate at offset k is window bits k..k+9, and its bit 0 is the first bit of the character. `alignedChar` is the window slice at the offset in force after that cycle's update, registered.
- R3: With `frameMode`=0 (fast), every detected framing character moves the boundary to its offset at the same clock edge. The framing character itself is output aligned in that cycle.
- R4: While `reframeEn` is low, `boundaryOff` does not change, no pulse is raised, and framing characters seen in that time do not count toward a later confirmation.
- R5: With `frameSel`=0, a match is window slice bits 0..6 equal to 1111100 or 0000011 (value order, bit 6 first). With `frameSel`=1, the whole 10-bit slice must equal 0101111100 or 1010000011. A comma-only character such as 0001111100 is ignored when `frameSel`=1.
- R6: With `frameMode`=1 (paired), the boundary moves on the second of two framing characters at the same offset when the second starts 1 to 4 slots after the first. Nothing changes on the first one.
- R7: In paired mode, a second character 5 or more slots after the first does not move the boundary.
- R8: With `frameMode`=2 or 3 (run), the boundary moves on the fourth of four framing characters at the same offset in consecutive slots.
- R9: In run mode, three matches, or a run broken by a slot with no match, do not move the boundary.
- R10: In either confirmed mode, a framing character at a different offset from the one being tracked restarts the confirmation from the new offset.
- R11: `realignPulse` is high for exactly the one cycle in which `boundaryOff` takes a value different from its previous one. A detection at the current offset raises no pulse.
- R12: When several offsets match in the same cycle, the lowest offset is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous reset, active high |
| rxWord | input | 10 | Ten raw received bits, bit 0 earliest |
| frameMode | input | 2 | 0 fast, 1 paired, 2 or 3 run of four |
| frameSel | input | 1 | 0 comma only, 1 full K28.5 |
| reframeEn | input | 1 | Allows the boundary to move when high |
| alignedChar | output | 10 | Character at the current boundary, bit 0 first |
| boundaryOff | output | 4 | Boundary offset in force, 0..9 |
| realignPulse | output | 1 | One-cycle strobe on a boundary change |

## Verification
The bench builds the framer with its default parameters: 10-bit characters, a 50-bit pairing span (a gap of up to four slots) and a run length of four. Because these values are small, every one of the ten offsets can be swept in each mode and under both framing selections and both disparities. The pairing gap is stepped from one to five slots, which lands on both sides of the span limit, and runs of three and four bracket the run length. Slip bits placed between characters shift the stream to a new offset in mid-stream, and this is how the restart rule and the back-to-back fast realignments are exercised.

// File: rtl/framer_pkg.sv
package framer_pkg;
  localparam int CHAR_W  = 10;
  localparam int OFF_W   = $clog2(CHAR_W);
  localparam int COMMA_W = 7;

  // Bit 0 of each constant is the first bit on the line.
  localparam logic [COMMA_W-1:0] COMMA_POS = 7'b1111100;
  localparam logic [COMMA_W-1:0] COMMA_NEG = 7'b0000011;
  localparam logic [CHAR_W-1:0]  K285_POS  = 10'b0101111100;
  localparam logic [CHAR_W-1:0]  K285_NEG  = 10'b1010000011;

  typedef enum logic [1:0] {
    MODE_FAST    = 2'd0,
    MODE_PAIR    = 2'd1,
    MODE_RUN     = 2'd2,
    MODE_RUN_ALT = 2'd3
  } frame_mode_e;

  typedef struct packed {
    logic             load;
    logic [OFF_W-1:0] newOff;
  } align_cmd_t;
endpackage

// File: rtl/framer_datapath.sv
module framer_datapath
  import framer_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CHAR_W-1:0] rxWord,
  input  logic              frameSel,
  input  align_cmd_t        cmd,
  output logic              candValid,
  output logic [OFF_W-1:0]  candOff,
  output logic [OFF_W-1:0]  curOff,
  output logic [CHAR_W-1:0] alignedChar,
  output logic              realignPulse
);
  logic [CHAR_W-1:0]   prevWord;
  logic [2*CHAR_W-1:0] window;
  logic [CHAR_W-1:0]   hit;
  logic [OFF_W-1:0]    offReg;
  logic [OFF_W-1:0]    nextOff;

  assign window = {rxWord, prevWord};

  generate
    for (genvar k = 0; k < CHAR_W; k++) begin : g_slot
      logic [CHAR_W-1:0] slice;
      logic              fullHit;
      logic              commaHit;
      assign slice    = window[k +: CHAR_W];
      assign fullHit  = (slice == K285_POS) || (slice == K285_NEG);
      assign commaHit = (slice[COMMA_W-1:0] == COMMA_POS) ||
                        (slice[COMMA_W-1:0] == COMMA_NEG);
      assign hit[k]   = frameSel ? fullHit : commaHit;
    end
  endgenerate

  // Lowest matching offset wins.
  always_comb begin
    candValid = 1'b0;
    candOff   = '0;
    for (int k = CHAR_W - 1; k >= 0; k--) begin
      if (hit[k]) begin
        candValid = 1'b1;
        candOff   = OFF_W'(k);
      end
    end
  end

  assign nextOff = cmd.load ? cmd.newOff : offReg;
  assign curOff  = offReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      prevWord     <= '0;
      offReg       <= '0;
      alignedChar  <= '0;
      realignPulse <= 1'b0;
    end else begin
      prevWord     <= rxWord;
      offReg       <= nextOff;
      alignedChar  <= window[nextOff +: CHAR_W];
      realignPulse <= cmd.load && (cmd.newOff != offReg);
    end
  end
endmodule

// File: rtl/framer_control.sv
module framer_control
  import framer_pkg::*;
#(
  parameter int PAIR_GAP = 4,
  parameter int RUN_LEN  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       frameMode,
  input  logic             reframeEn,
  input  logic             candValid,
  input  logic [OFF_W-1:0] candOff,
  output align_cmd_t       cmd
);
  localparam int AGE_W = $clog2(PAIR_GAP + 1);
  localparam int RUN_W = $clog2(RUN_LEN + 1);

  frame_mode_e      mode;
  logic             live;
  logic             pendValid;
  logic [OFF_W-1:0] pendOff;
  logic [AGE_W-1:0] pendAge;
  logic             pairHit;
  logic [RUN_W-1:0] runCnt;
  logic [RUN_W-1:0] runNext;
  logic [OFF_W-1:0] runOff;
  logic             runDone;

  assign mode    = frame_mode_e'(frameMode);
  assign live    = candValid && reframeEn;
  assign pairHit = live && pendValid && (candOff == pendOff);

  always_comb begin
    if (!live)
      runNext = '0;
    else if ((runCnt != '0) && (candOff == runOff))
      runNext = runCnt + RUN_W'(1);
    else
      runNext = RUN_W'(1);
    runDone = live && (runNext == RUN_W'(RUN_LEN));
  end

  always_comb begin
    cmd.newOff = candOff;
    case (mode)
      MODE_FAST: cmd.load = live;
      MODE_PAIR: cmd.load = pairHit;
      default:   cmd.load = runDone;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !reframeEn) begin
      pendValid <= 1'b0;
      pendOff   <= '0;
      pendAge   <= '0;
    end else if (pairHit) begin
      pendValid <= 1'b0;
    end else if (live) begin
      pendValid <= 1'b1;
      pendOff   <= candOff;
      pendAge   <= AGE_W'(1);
    end else if (pendValid) begin
      if (pendAge == AGE_W'(PAIR_GAP))
        pendValid <= 1'b0;
      else
        pendAge <= pendAge + AGE_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !reframeEn) begin
      runCnt <= '0;
      runOff <= '0;
    end else begin
      runCnt <= runDone ? '0 : runNext;
      if (live) runOff <= candOff;
    end
  end
endmodule

// File: rtl/comma_framer.sv
module comma_framer
  import framer_pkg::*;
#(
  parameter int PAIR_SPAN_BITS = 50,
  parameter int RUN_LEN        = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CHAR_W-1:0] rxWord,
  input  logic [1:0]        frameMode,
  input  logic              frameSel,
  input  logic              reframeEn,
  output logic [CHAR_W-1:0] alignedChar,
  output logic [OFF_W-1:0]  boundaryOff,
  output logic              realignPulse
);
  localparam int PAIR_GAP = PAIR_SPAN_BITS / CHAR_W - 1;

  align_cmd_t       cmd;
  logic             candValid;
  logic [OFF_W-1:0] candOff;

  framer_datapath u_dp (
    .clk(clk), .rst(rst), .rxWord(rxWord), .frameSel(frameSel), .cmd(cmd),
    .candValid(candValid), .candOff(candOff), .curOff(boundaryOff),
    .alignedChar(alignedChar), .realignPulse(realignPulse)
  );

  framer_control #(.PAIR_GAP(PAIR_GAP), .RUN_LEN(RUN_LEN)) u_ctl (
    .clk(clk), .rst(rst), .frameMode(frameMode), .reframeEn(reframeEn),
    .candValid(candValid), .candOff(candOff), .cmd(cmd)
  );
endmodule

// File: rtl/comma_framer_chk.sv
module comma_framer_chk
  import framer_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             reframeEn,
  input logic [OFF_W-1:0] boundaryOff,
  input logic             realignPulse
);
  AST_FROZEN_WHEN_DISABLED: assert property (@(posedge clk) disable iff (rst)
    !reframeEn |=> $stable(boundaryOff)); // R4
  AST_PULSE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    realignPulse |-> $past(reframeEn)); // R4
  AST_PULSE_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
    realignPulse |-> (boundaryOff != $past(boundaryOff))); // R11
  AST_CHANGE_HAS_PULSE: assert property (@(posedge clk) disable iff (rst)
    (boundaryOff != $past(boundaryOff)) |-> realignPulse); // R11
  AST_OFFSET_RANGE: assert property (@(posedge clk) disable iff (rst)
    boundaryOff < OFF_W'(CHAR_W)); // R2
endmodule

bind comma_framer comma_framer_chk u_chk (.*);

// File: tb/tb_comma_framer.sv
module tb_comma_framer;
  import framer_pkg::*;

  localparam time CLK_P = 4ns;
  localparam logic [9:0] FILL = 10'b0101010101;
  localparam logic [9:0] KP   = 10'b0101111100;
  localparam logic [9:0] KN   = 10'b1010000011;
  localparam logic [9:0] K287 = 10'b0001111100;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] rxWord = '0;
  logic [1:0] frameMode = 2'd0;
  logic       frameSel = 1'b0;
  logic       reframeEn = 1'b1;
  logic [9:0] alignedChar;
  logic [3:0] boundaryOff;
  logic       realignPulse;

  int nChecks = 0;
  int nFail = 0;

  bit         q[$];
  logic [9:0] outChars [0:63];
  int         offs [0:63];
  bit         pulseAt [0:63];
  int         pulses;
  int         finalOff;

  comma_framer dut (
    .clk(clk), .rst(rst), .rxWord(rxWord), .frameMode(frameMode),
    .frameSel(frameSel), .reframeEn(reframeEn), .alignedChar(alignedChar),
    .boundaryOff(boundaryOff), .realignPulse(realignPulse)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic addChar(input logic [9:0] c);
    for (int j = 0; j < 10; j++) q.push_back(c[j]);
  endtask

  task automatic addSlip(input int n);
    for (int i = 0; i < n; i++) begin
      bit last;
      last = (q.size() > 0) ? q[q.size()-1] : 1'b0;
      q.push_back(~last);
    end
  endtask

  task automatic setup(input int mode, input bit sel, input bit en);
    q.delete();
    frameMode = mode[1:0];
    frameSel  = sel;
    reframeEn = en;
  endtask

  task automatic runStream();
    int t;
    addChar(FILL);
    addChar(FILL);
    while (q.size() % 10 != 0) addSlip(1);
    for (int i = 0; i < 64; i++) begin
      outChars[i] = 'x; offs[i] = -1; pulseAt[i] = 0;
    end
    rst = 1'b1;
    rxWord = '0;
    repeat (2) @(posedge clk);
    #1;
    chk(boundaryOff == 0, "R1 offset", int'(boundaryOff), 0);
    chk(realignPulse == 0, "R1 pulse", int'(realignPulse), 0);
    chk(alignedChar == 0, "R1 char", int'(alignedChar), 0);
    rst = 1'b0;
    pulses = 0;
    t = 0;
    while (q.size() >= 10) begin
      logic [9:0] w;
      for (int j = 0; j < 10; j++) w[j] = q.pop_front();
      rxWord = w;
      @(posedge clk);
      #1;
      if (t < 64) begin
        outChars[t] = alignedChar;
        offs[t]     = int'(boundaryOff);
        pulseAt[t]  = realignPulse;
      end
      if (realignPulse) pulses++;
      t++;
    end
    finalOff = int'(boundaryOff);
  endtask

  initial begin
    // R3 R2 R11 R5: fast mode, every offset, both selections and disparities
    for (int sel = 0; sel < 2; sel++)
      for (int pol = 0; pol < 2; pol++)
        for (int k = 0; k < 10; k++) begin
          logic [9:0] kc;
          kc = pol ? KN : KP;
          setup(0, sel[0], 1'b1);
          addChar(FILL); addChar(FILL); addSlip(k); addChar(kc); addChar(FILL);
          runStream();
          chk(offs[2] == 0, "R3 before", offs[2], 0);
          chk(finalOff == k, "R3 offset", finalOff, k);
          chk(outChars[3] == kc, "R2 aligned char", int'(outChars[3]), int'(kc));
          chk(outChars[4] == FILL, "R2 next char", int'(outChars[4]), int'(FILL));
          chk(pulses == ((k != 0) ? 1 : 0), "R11 pulse count", pulses, (k != 0) ? 1 : 0);
          if (k != 0) chk(pulseAt[3] == 1, "R11 pulse cycle", int'(pulseAt[3]), 1);
        end

    // R3: two fast realignments in a row
    setup(0, 1'b1, 1'b1);
    addChar(FILL); addChar(FILL); addSlip(2); addChar(KP); addSlip(5); addChar(KP); addChar(FILL);
    runStream();
    chk(offs[3] == 2, "R3 first move", offs[3], 2);
    chk(finalOff == 7, "R3 second move", finalOff, 7);
    chk(pulses == 2, "R3 pulses", pulses, 2);

    // R12: two matches in one window, lowest offset taken
    setup(0, 1'b0, 1'b1);
    addChar(FILL); addChar(FILL); addSlip(1); addChar(K287); addChar(K287); addChar(FILL);
    runStream();
    chk(offs[3] == 1, "R12 lowest offset", offs[3], 1);

    // R4: frozen while reframe is disabled
    for (int k = 1; k < 10; k++) begin
      setup(0, 1'b1, 1'b0);
      addChar(FILL); addChar(FILL); addSlip(k); addChar(KP); addChar(FILL);
      runStream();
      chk(finalOff == 0, "R4 frozen offset", finalOff, 0);
      chk(pulses == 0, "R4 no pulse", pulses, 0);
    end
    setup(2, 1'b0, 1'b0);
    addChar(FILL); addChar(FILL); addSlip(6);
    for (int i = 0; i < 4; i++) addChar(KN);
    runStream();
    chk(finalOff == 0, "R4 run mode frozen", finalOff, 0);

    // R5: comma-only character ignored under full selection, accepted under comma
    setup(0, 1'b1, 1'b1);
    addChar(FILL); addChar(FILL); addSlip(3); addChar(K287); addChar(FILL);
    runStream();
    chk(finalOff == 0, "R5 full select ignores comma-only", finalOff, 0);
    setup(0, 1'b0, 1'b1);
    addChar(FILL); addChar(FILL); addSlip(3); addChar(K287); addChar(FILL);
    runStream();
    chk(finalOff == 3, "R5 comma select", finalOff, 3);
    chk(outChars[3] == K287, "R5 aligned", int'(outChars[3]), int'(K287));

    // R6 R7: paired mode, gaps 1..5 at every nonzero offset
    for (int k = 1; k < 10; k++)
      for (int d = 1; d <= 5; d++) begin
        setup(1, 1'b1, 1'b1);
        addChar(FILL); addChar(FILL); addSlip(k); addChar(KP);
        for (int i = 1; i < d; i++) addChar(FILL);
        addChar(KP); addChar(FILL);
        runStream();
        if (d <= 4) begin
          chk(offs[2+d] == 0, "R6 held until second", offs[2+d], 0);
          chk(pulseAt[3+d] == 1, "R6 move on second", int'(pulseAt[3+d]), 1);
          chk(finalOff == k, "R6 offset", finalOff, k);
          chk(pulses == 1, "R6 pulses", pulses, 1);
        end else begin
          chk(finalOff == 0, "R7 beyond span", finalOff, 0);
          chk(pulses == 0, "R7 pulses", pulses, 0);
        end
      end

    // R10: paired restart on a new offset
    setup(1, 1'b1, 1'b1);
    addChar(FILL); addChar(FILL); addSlip(2); addChar(KP); addSlip(3); addChar(KP);
    addChar(FILL); addChar(KP); addChar(FILL);
    runStream();
    chk(offs[5] == 0, "R10 pair no early move", offs[5], 0);
    chk(pulseAt[6] == 1, "R10 pair confirm", int'(pulseAt[6]), 1);
    chk(finalOff == 5, "R10 pair offset", finalOff, 5);
    chk(pulses == 1, "R10 pair pulses", pulses, 1);

    // R8 R9: run mode, runs of three and four at every nonzero offset
    for (int k = 1; k < 10; k++)
      for (int n = 3; n <= 4; n++) begin
        setup(2, 1'b0, 1'b1);
        addChar(FILL); addChar(FILL); addSlip(k);
        for (int i = 0; i < n; i++) addChar(KN);
        addChar(FILL);
        runStream();
        if (n == 4) begin
          chk(offs[5] == 0, "R8 held before fourth", offs[5], 0);
          chk(pulseAt[6] == 1, "R8 move on fourth", int'(pulseAt[6]), 1);
          chk(finalOff == k, "R8 offset", finalOff, k);
        end else begin
          chk(finalOff == 0, "R9 three only", finalOff, 0);
        end
      end

    // R9: broken run
    setup(2, 1'b1, 1'b1);
    addChar(FILL); addChar(FILL); addSlip(4);
    addChar(KP); addChar(KP); addChar(KP); addChar(FILL); addChar(KP);
    runStream();
    chk(finalOff == 0, "R9 broken run", finalOff, 0);
    chk(pulses == 0, "R9 pulses", pulses, 0);

    // R8: encoding 3 also runs the four-in-a-row policy
    setup(3, 1'b1, 1'b1);
    addChar(FILL); addChar(FILL); addSlip(2);
    for (int i = 0; i < 4; i++) addChar(KP);
    runStream();
    chk(finalOff == 2, "R8 alternate encoding", finalOff, 2);

    // R10: run restart on a new offset
    setup(2, 1'b1, 1'b1);
    addChar(FILL); addChar(FILL); addSlip(1);
    for (int i = 0; i < 3; i++) addChar(KP);
    addSlip(4);
    for (int i = 0; i < 4; i++) addChar(KP);
    addChar(FILL);
    runStream();
    chk(offs[8] == 0, "R10 run no early move", offs[8], 0);
    chk(pulseAt[9] == 1, "R10 run confirm", int'(pulseAt[9]), 1);
    chk(finalOff == 5, "R10 run offset", finalOff, 5);
    chk(pulses == 1, "R10 run pulses", pulses, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule